// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sequences the transmission of an in-frame response on a J1850-style multiplex bus. Software parks the first response byte in a data register and arms a request bit while the originating frame is still on the bus. When the bus reports a valid end-of-data symbol, the sequencer hands a normalization bit to the symbol transmitter, then shifts out response bytes most significant bit first. It asks for each next byte through a data-register-empty interrupt. When software marks the final byte, it closes the response with a CRC byte and an end-of-data symbol.

The bus side is a single symbol handshake. The block presents one symbol (its kind and, for data, its bit value) and holds it until the transmitter pulses `sym_done`. Arbitration loss is reported with the `sym_done` pulse of the bit on which it happened. Arbitration loss, bus error and transmitter underrun each abort the response, clear the request and set their own sticky status flag. Arbitration lost on the final bit of a byte is the one exception to an immediate stop: two logic-1 bits are sent first, so that receivers see a byte-boundary fault.

Top module: `ifr_tx_seq`

## Requirements
- R1: After reset, `sym_valid`, `arm_bit`, `last_bit`, `dre_irq` and the three flags are all 0.
- R2: `cpu_arm` sets `arm_bit` only while the sequencer is idle and `eod_seen` is low both in that cycle and in the cycle before. Any other attempt leaves `arm_bit` at 0.
- R3: An `eod_seen` pulse with `eod_crc_ok`=1 while armed starts a response. The first symbol is a normalization bit (`sym_kind`=1), followed by the data-register byte as eight data symbols (`sym_kind`=0) MSB first. An `eod_seen` pulse with `eod_crc_ok`=0 clears `arm_bit` and starts nothing.
- R4: Each move of the data register into the shift register while `last_bit` is 0 gives exactly one one-cycle `dre_irq` pulse.
- R5: With `last_bit` set, the byte in the data register is sent, then one CRC byte, then one end-of-data symbol (`sym_kind`=2). After that the sequencer is idle with `arm_bit` and `last_bit` cleared.
- R6: The CRC byte is the complement of a CRC-8 remainder (polynomial 0x1D, start value 0xFF) over the response bytes taken MSB first. A single 0x00 byte gives 0x3B.
- R7: If `last_bit` is set before the first byte is loaded, that byte is the only one before the CRC and no `dre_irq` occurs.
- R8: A byte finishing with the data register empty and `last_bit` clear is an underrun. It sets `flag_unr`, clears `arm_bit`, and nothing more is sent.
- R9: Arbitration lost on any bit of a response byte other than its last sets `flag_arb` and clears `arm_bit`. `sym_valid` is 0 in the next cycle and the byte is not retried.
- R10: Arbitration lost on the last bit of a response byte sets `flag_arb` and sends exactly two more data symbols of value 1, then goes idle.
- R11: `bus_err` while armed or active sets `flag_err`, clears `arm_bit`, and makes `sym_valid` 0 in the next cycle. While idle and unarmed it has no effect.
- R12: Each flag stays set until its `cpu_flag_clr` bit is pulsed. Bit 0 clears `flag_arb`, bit 1 clears `flag_err` and bit 2 clears `flag_unr`.
- R13: After any abort, the CRC of the next response starts again from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_data | input | 1 | Write strobe for the data register |
| cpu_wdata | input | BYTE_W | Byte written to the data register |
| cpu_arm | input | 1 | Attempt to set the request bit |
| cpu_last | input | 1 | Mark the data-register byte as the final one |
| cpu_flag_clr | input | 3 | Per-flag clear strobes (arb, err, underrun) |
| arm_bit | output | 1 | Request bit state |
| last_bit | output | 1 | End-of-data bit state |
| dre_irq | output | 1 | Data-register-empty pulse |
| flag_arb | output | 1 | Sticky arbitration-loss flag |
| flag_err | output | 1 | Sticky bus-error flag |
| flag_unr | output | 1 | Sticky underrun flag |
| eod_seen | input | 1 | End-of-data symbol received (pulse) |
| eod_crc_ok | input | 1 | Received frame had a good CRC, valid with `eod_seen` |
| sym_valid | output | 1 | A symbol is being presented |
| sym_kind | output | 2 | 0 data bit, 1 normalization bit, 2 end-of-data |
| sym_bit | output | 1 | Data bit value |
| sym_done | input | 1 | Transmitter finished the current symbol |
| arb_lost | input | 1 | Arbitration lost on the bit ending with `sym_done` |
| bus_err | input | 1 | Bus error detected |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, the 0x1D polynomial with a 0xFF start value, and two padding bits. Under these values the CRC results are the standard 8-bit ones, so a hand-derived value such as 0x3B for a lone zero byte is checked alongside a bit-serial model. With an 8-bit counter, arbitration loss can be placed on bit 7 of a byte to reach the padding path and on a middle bit to reach the immediate stop. A 2-deep padding counter shows whether exactly two fill bits leave the block.

// File: rtl/ifr_tx_pkg.sv
// Shared codes for the in-frame response sequencer.
// Assumes: symbol kinds are decoded by the bit-level transmitter.
package ifr_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_DATA,
        ST_CRC,
        ST_EOD,
        ST_PAD
    } seq_state_t;

    localparam logic [1:0] KIND_DATA = 2'd0;
    localparam logic [1:0] KIND_NORM = 2'd1;
    localparam logic [1:0] KIND_EOD  = 2'd2;

    localparam int NFLAG   = 3;
    localparam int FLG_ARB = 0;
    localparam int FLG_ERR = 1;
    localparam int FLG_UNR = 2;
endpackage

// File: rtl/ifr_crc_gen.sv
// Byte-wide CRC accumulator for response bytes, MSB first.
// Assumes: init and upd are never high in the same cycle; init wins if they are.
module ifr_crc_gen #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    POLY = 8'h1D,
    parameter logic [W-1:0]    INIT = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);
    // One full byte of polynomial division.
    function automatic logic [W-1:0] step_byte(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r;
        r = c ^ d;
        for (int i = 0; i < W; i++) begin
            r = r[W-1] ? ((r << 1) ^ POLY) : (r << 1);
        end
        return r;
    endfunction

    // Holds the running remainder; restarts on init.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= INIT;
        else if (init)  crc_q <= INIT;
        else if (upd)   crc_q <= step_byte(crc_q, din);
    end
endmodule

// File: rtl/ifr_cpu_regs.sv
// Processor-facing state: data register, request and end-of-data bits,
// empty interrupt and sticky status flags.
// Assumes: event strobes from the sequencer are single-cycle.
module ifr_cpu_regs
    import ifr_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_data,
    input  logic [W-1:0]     cpu_wdata,
    input  logic             cpu_arm,
    input  logic             cpu_last,
    input  logic [NFLAG-1:0] cpu_flag_clr,
    input  logic             eod_seen,
    input  logic             eod_crc_ok,
    input  logic             bus_err,
    input  logic             seq_idle,
    input  logic             ld_dr,
    input  logic             done_ok,
    input  logic             ev_arb,
    input  logic             ev_unr,
    output logic [W-1:0]     dr_q,
    output logic             dr_full,
    output logic             arm_bit,
    output logic             last_bit,
    output logic             dre_irq,
    output logic             err_hit,
    output logic [NFLAG-1:0] flags
);
    logic             eod_d;
    logic             arm_ok;
    logic             drop_req;
    logic [NFLAG-1:0] set_v;

    // Decode which requests are accepted and which events drop the request.
    always_comb begin
        err_hit  = bus_err && (arm_bit || !seq_idle);
        arm_ok   = cpu_arm && seq_idle && !eod_seen && !eod_d;
        drop_req = err_hit || done_ok || ev_arb || ev_unr ||
                   (seq_idle && eod_seen && !eod_crc_ok);
        set_v    = '0;
        set_v[FLG_ARB] = ev_arb;
        set_v[FLG_ERR] = err_hit;
        set_v[FLG_UNR] = ev_unr;
    end

    // Remembers the previous end-of-data cycle for the arming window.
    always_ff @(posedge clk) begin
        if (!rst_n) eod_d <= 1'b0;
        else        eod_d <= eod_seen;
    end

    // Request and end-of-data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_bit  <= 1'b0;
            last_bit <= 1'b0;
        end else if (drop_req) begin
            arm_bit  <= 1'b0;
            last_bit <= 1'b0;
        end else begin
            if (arm_ok)              arm_bit  <= 1'b1;
            if (cpu_last && arm_bit) last_bit <= 1'b1;
        end
    end

    // Data register and its full marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q    <= '0;
            dr_full <= 1'b0;
        end else if (cpu_wr_data) begin
            dr_q    <= cpu_wdata;
            dr_full <= 1'b1;
        end else if (ld_dr) begin
            dr_full <= 1'b0;
        end
    end

    // Empty interrupt: one pulse per load while more bytes are expected.
    always_ff @(posedge clk) begin
        if (!rst_n) dre_irq <= 1'b0;
        else        dre_irq <= ld_dr && !last_bit;
    end

    // Sticky flags, one register each; set wins over clear.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (!rst_n)               f_q <= 1'b0;
            else if (set_v[g])        f_q <= 1'b1;
            else if (cpu_flag_clr[g]) f_q <= 1'b0;
        end
        assign flags[g] = f_q;
    end
endmodule

// File: rtl/ifr_tx_fsm.sv
// Response sequencer: normalization bit, data bytes, CRC byte, end-of-data,
// plus the fill bits after arbitration is lost on a byte's last bit.
// Assumes: sym_done is a one-cycle pulse; arb_lost is valid with sym_done.
module ifr_tx_fsm
    import ifr_tx_pkg::*;
#(
    parameter int W        = 8,
    parameter int PAD_BITS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eod_seen,
    input  logic         eod_crc_ok,
    input  logic         arm_bit,
    input  logic         last_bit,
    input  logic         dr_full,
    input  logic [W-1:0] dr_q,
    input  logic [W-1:0] crc_q,
    input  logic         sym_done,
    input  logic         arb_lost,
    input  logic         err_hit,
    output logic         seq_idle,
    output logic         crc_clr,
    output logic         ld_dr,
    output logic         done_ok,
    output logic         ev_arb,
    output logic         ev_unr,
    output logic         sym_valid,
    output logic [1:0]   sym_kind,
    output logic         sym_bit
);
    localparam int             CNT_W    = (W > 1) ? $clog2(W) : 1;
    localparam int             PAD_W    = $clog2(PAD_BITS) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
    localparam logic [PAD_W-1:0] LAST_PAD = PAD_W'(PAD_BITS - 1);

    seq_state_t       st;
    logic [W-1:0]     sh;
    logic [CNT_W-1:0] cnt;
    logic [PAD_W-1:0] pcnt;
    logic             in_byte;
    logic             start;
    logic             arb_hit;
    logic             fetch;
    logic             ld_crc;

    // Event decode for this cycle.
    always_comb begin
        in_byte  = (st == ST_DATA) || (st == ST_CRC);
        seq_idle = (st == ST_IDLE);
        start    = seq_idle && eod_seen && eod_crc_ok && arm_bit && !err_hit;
        arb_hit  = in_byte && sym_done && arb_lost && !err_hit;
        fetch    = !err_hit && !arb_hit && sym_done &&
                   ((st == ST_NORM) || ((st == ST_DATA) && (cnt == LAST_BIT)));
        ld_dr    = fetch && dr_full;
        ld_crc   = fetch && !dr_full && last_bit && (st == ST_DATA);
        ev_unr   = fetch && !dr_full && !ld_crc;
        ev_arb   = arb_hit;
        done_ok  = (st == ST_EOD) && sym_done && !err_hit;
        crc_clr  = start || err_hit || arb_hit || ev_unr;
    end

    // Symbol presented to the bit-level transmitter.
    always_comb begin
        sym_valid = !seq_idle;
        sym_bit   = (st == ST_PAD) ? 1'b1 : sh[W-1];
        case (st)
            ST_NORM: sym_kind = KIND_NORM;
            ST_EOD:  sym_kind = KIND_EOD;
            default: sym_kind = KIND_DATA;
        endcase
    end

    // State, shift register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            sh   <= '0;
            cnt  <= '0;
            pcnt <= '0;
        end else if (err_hit) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (start) st <= ST_NORM;
                ST_NORM: if (sym_done) begin
                    if (ld_dr) begin
                        st  <= ST_DATA;
                        sh  <= dr_q;
                        cnt <= '0;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_DATA, ST_CRC: if (arb_hit) begin
                    if (cnt == LAST_BIT) begin
                        st   <= ST_PAD;
                        pcnt <= '0;
                    end else begin
                        st <= ST_IDLE;
                    end
                end else if (sym_done) begin
                    if (cnt != LAST_BIT) begin
                        sh  <= sh << 1;
                        cnt <= cnt + 1'b1;
                    end else if (st == ST_CRC) begin
                        st <= ST_EOD;
                    end else if (ld_dr) begin
                        sh  <= dr_q;
                        cnt <= '0;
                    end else if (ld_crc) begin
                        st  <= ST_CRC;
                        sh  <= ~crc_q;
                        cnt <= '0;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_EOD: if (sym_done) st <= ST_IDLE;
                ST_PAD: if (sym_done) begin
                    if (pcnt == LAST_PAD) st <= ST_IDLE;
                    else                  pcnt <= pcnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ifr_tx_seq.sv
// Top of the in-frame response transmit sequencer: joins the register
// side, the CRC accumulator and the symbol sequencer.
// Assumes: one clock domain; all bus inputs already synchronized.
module ifr_tx_seq
    import ifr_tx_pkg::*;
#(
    parameter int                 BYTE_W   = 8,
    parameter logic [BYTE_W-1:0]  CRC_POLY = 8'h1D,
    parameter logic [BYTE_W-1:0]  CRC_INIT = 8'hFF,
    parameter int                 PAD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_data,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cpu_arm,
    input  logic              cpu_last,
    input  logic [2:0]        cpu_flag_clr,
    output logic              arm_bit,
    output logic              last_bit,
    output logic              dre_irq,
    output logic              flag_arb,
    output logic              flag_err,
    output logic              flag_unr,
    input  logic              eod_seen,
    input  logic              eod_crc_ok,
    output logic              sym_valid,
    output logic [1:0]        sym_kind,
    output logic              sym_bit,
    input  logic              sym_done,
    input  logic              arb_lost,
    input  logic              bus_err
);
    logic [BYTE_W-1:0] dr_q;
    logic [BYTE_W-1:0] crc_q;
    logic              dr_full;
    logic              err_hit;
    logic              seq_idle;
    logic              crc_clr;
    logic              ld_dr;
    logic              done_ok;
    logic              ev_arb;
    logic              ev_unr;
    logic [NFLAG-1:0]  flags;

    ifr_cpu_regs #(.W(BYTE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_wr_data  (cpu_wr_data),
        .cpu_wdata    (cpu_wdata),
        .cpu_arm      (cpu_arm),
        .cpu_last     (cpu_last),
        .cpu_flag_clr (cpu_flag_clr),
        .eod_seen     (eod_seen),
        .eod_crc_ok   (eod_crc_ok),
        .bus_err      (bus_err),
        .seq_idle     (seq_idle),
        .ld_dr        (ld_dr),
        .done_ok      (done_ok),
        .ev_arb       (ev_arb),
        .ev_unr       (ev_unr),
        .dr_q         (dr_q),
        .dr_full      (dr_full),
        .arm_bit      (arm_bit),
        .last_bit     (last_bit),
        .dre_irq      (dre_irq),
        .err_hit      (err_hit),
        .flags        (flags)
    );

    ifr_crc_gen #(.W(BYTE_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_clr),
        .upd   (ld_dr),
        .din   (dr_q),
        .crc_q (crc_q)
    );

    ifr_tx_fsm #(.W(BYTE_W), .PAD_BITS(PAD_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eod_seen   (eod_seen),
        .eod_crc_ok (eod_crc_ok),
        .arm_bit    (arm_bit),
        .last_bit   (last_bit),
        .dr_full    (dr_full),
        .dr_q       (dr_q),
        .crc_q      (crc_q),
        .sym_done   (sym_done),
        .arb_lost   (arb_lost),
        .err_hit    (err_hit),
        .seq_idle   (seq_idle),
        .crc_clr    (crc_clr),
        .ld_dr      (ld_dr),
        .done_ok    (done_ok),
        .ev_arb     (ev_arb),
        .ev_unr     (ev_unr),
        .sym_valid  (sym_valid),
        .sym_kind   (sym_kind),
        .sym_bit    (sym_bit)
    );

    assign flag_arb = flags[FLG_ARB];
    assign flag_err = flags[FLG_ERR];
    assign flag_unr = flags[FLG_UNR];
endmodule

// File: rtl/ifr_tx_seq_chk.sv
// Port-level properties of the response sequencer, bound to its top.
// Assumes: synchronous active-low reset shared with the design.
module ifr_tx_seq_chk
    import ifr_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       arm_bit,
    input logic       dre_irq,
    input logic       flag_arb,
    input logic       flag_err,
    input logic       flag_unr,
    input logic       cpu_flag_clr_unr,
    input logic       eod_seen,
    input logic       sym_valid,
    input logic [1:0] sym_kind,
    input logic       sym_bit,
    input logic       sym_done,
    input logic       arb_lost,
    input logic       bus_err
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dre_irq |=> !dre_irq); // R4

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eod_seen && !arm_bit) |=> !arm_bit); // R2

    AST_NORM_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_valid) |-> (sym_kind == KIND_NORM)); // R3

    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_done && !bus_err) |=>
            (sym_valid && $stable(sym_kind) && $stable(sym_bit))); // R3

    AST_ARB_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_done && arb_lost && !bus_err && arm_bit &&
         sym_kind == KIND_DATA) |=> (!arm_bit && flag_arb)); // R9

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && (arm_bit || sym_valid)) |=> (!sym_valid && !arm_bit && flag_err)); // R11

    AST_UNR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unr && !cpu_flag_clr_unr) |=> flag_unr); // R12
endmodule

bind ifr_tx_seq ifr_tx_seq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .arm_bit          (arm_bit),
    .dre_irq          (dre_irq),
    .flag_arb         (flag_arb),
    .flag_err         (flag_err),
    .flag_unr         (flag_unr),
    .cpu_flag_clr_unr (cpu_flag_clr[2]),
    .eod_seen         (eod_seen),
    .sym_valid        (sym_valid),
    .sym_kind         (sym_kind),
    .sym_bit          (sym_bit),
    .sym_done         (sym_done),
    .arb_lost         (arb_lost),
    .bus_err          (bus_err)
);

// File: tb/ifr_tx_seq_bench.sv
// Bench for the response sequencer: table-driven frames, then directed cases.
module ifr_tx_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;
    localparam int NVEC       = 5;
    // {early_last, count, b0, b1, b2}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd0, 8'd1, 8'h00, 8'h00, 8'h00},
        {8'd1, 8'd1, 8'hA5, 8'h00, 8'h00},
        {8'd0, 8'd2, 8'h12, 8'h34, 8'h00},
        {8'd0, 8'd3, 8'hFF, 8'h00, 8'h81},
        {8'd0, 8'd3, 8'h55, 8'hAA, 8'h0F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_data = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_arm = 1'b0;
    logic       cpu_last = 1'b0;
    logic [2:0] cpu_flag_clr = '0;
    logic       eod_seen = 1'b0;
    logic       eod_crc_ok = 1'b0;
    logic       sym_done = 1'b0;
    logic       arb_lost = 1'b0;
    logic       bus_err = 1'b0;
    logic       arm_bit, last_bit, dre_irq, flag_arb, flag_err, flag_unr;
    logic       sym_valid, sym_bit;
    logic [1:0] sym_kind;

    int total = 0;
    int bad = 0;
    logic [1:0] rec_kind [64];
    logic       rec_bit  [64];
    int         nrec;
    int         irq_cnt;
    logic [7:0] pay [4];
    int         npay;

    ifr_tx_seq u_ifr_tx_seq (
        .clk(clk), .rst_n(rst_n), .cpu_wr_data(cpu_wr_data), .cpu_wdata(cpu_wdata),
        .cpu_arm(cpu_arm), .cpu_last(cpu_last), .cpu_flag_clr(cpu_flag_clr),
        .arm_bit(arm_bit), .last_bit(last_bit), .dre_irq(dre_irq),
        .flag_arb(flag_arb), .flag_err(flag_err), .flag_unr(flag_unr),
        .eod_seen(eod_seen), .eod_crc_ok(eod_crc_ok), .sym_valid(sym_valid),
        .sym_kind(sym_kind), .sym_bit(sym_bit), .sym_done(sym_done),
        .arb_lost(arb_lost), .bus_err(bus_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference CRC, complemented.
    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[7] ^ pay[i][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        end
        return ~c;
    endfunction

    function automatic logic [7:0] rec_byte(input int idx);
        logic [7:0] v = '0;
        for (int b = 0; b < 8; b++) v = {v[6:0], rec_bit[1 + 8 * idx + b]};
        return v;
    endfunction

    // Arms a response with pay[0] loaded, then signals end-of-data.
    task automatic arm_and_eod(input logic early, input logic crc_ok);
        @(negedge clk); cpu_wr_data = 1'b1; cpu_wdata = pay[0];
        @(negedge clk); cpu_wr_data = 1'b0; cpu_arm = 1'b1;
        @(negedge clk); cpu_arm = 1'b0; cpu_last = early;
        @(negedge clk); cpu_last = 1'b0; eod_seen = 1'b1; eod_crc_ok = crc_ok;
        @(negedge clk); eod_seen = 1'b0; eod_crc_ok = 1'b0;
    endtask

    // Acts as transmitter and processor until the sequencer goes idle.
    task automatic run_tx(input logic feed, input int arb_at, input int err_at);
        int   idx = 1;
        logic drove = 1'b0;
        logic started = 1'b0;
        nrec = 0;
        irq_cnt = 0;
        for (int c = 0; c < 800; c++) begin
            if (c > 0) @(negedge clk);
            cpu_wr_data = 1'b0;
            cpu_last = 1'b0;
            if (dre_irq) begin
                irq_cnt++;
                if (feed) begin
                    if (idx < npay) begin
                        cpu_wr_data = 1'b1;
                        cpu_wdata = pay[idx];
                        idx++;
                        if (idx == npay) cpu_last = 1'b1;
                    end else begin
                        cpu_last = 1'b1;
                    end
                end
            end
            if (drove) begin
                sym_done = 1'b0; arb_lost = 1'b0; bus_err = 1'b0; drove = 1'b0;
                if (!sym_valid) break;
            end else if (sym_valid) begin
                started = 1'b1;
                rec_kind[nrec] = sym_kind;
                rec_bit[nrec] = sym_bit;
                if (nrec == err_at) bus_err = 1'b1;
                else begin
                    sym_done = 1'b1;
                    if (nrec == arb_at) arb_lost = 1'b1;
                end
                nrec++;
                drove = 1'b1;
            end else if (started || c > 12) begin
                break;
            end
        end
        cpu_wr_data = 1'b0;
        cpu_last = 1'b0;
    endtask

    // Checks a complete, successful response against the payload.
    task automatic chk_frame(input int exp_irq);
        logic [7:0] exp_crc = ref_crc(npay);
        chk(nrec == 10 + 8 * npay, "R5", "symbol count", nrec, 10 + 8 * npay);
        chk(rec_kind[0] == 2'd1, "R3", "first symbol kind", rec_kind[0], 1);
        for (int i = 0; i < npay; i++)
            chk(rec_byte(i) == pay[i], "R3", "data byte", rec_byte(i), pay[i]);
        chk(rec_byte(npay) == exp_crc, "R6", "crc byte", rec_byte(npay), exp_crc);
        chk(rec_kind[nrec - 1] == 2'd2, "R5", "closing symbol kind", rec_kind[nrec - 1], 2);
        chk(irq_cnt == exp_irq, "R4", "empty interrupts", irq_cnt, exp_irq);
        chk(!arm_bit && !last_bit, "R5", "request after close", {arm_bit, last_bit}, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!sym_valid && !arm_bit && !last_bit && !dre_irq, "R1", "outputs after reset",
            {sym_valid, arm_bit, last_bit, dre_irq}, 0);
        chk({flag_arb, flag_err, flag_unr} == 3'b000, "R1", "flags after reset",
            {flag_arb, flag_err, flag_unr}, 0);

        // Table of frames; R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic early = VEC[v][32];
            int   exp_irq;
            npay = int'(VEC[v][31:24]);
            pay[0] = VEC[v][23:16]; pay[1] = VEC[v][15:8]; pay[2] = VEC[v][7:0];
            exp_irq = early ? 0 : ((npay == 1) ? 1 : npay - 1);
            arm_and_eod(early, 1'b1);
            run_tx(1'b1, -1, -1);
            chk_frame(exp_irq);
            if (early) chk(irq_cnt == 0, "R7", "no interrupt with early end", irq_cnt, 0);
        end

        // R6 known value for a single zero byte
        npay = 1; pay[0] = 8'h00;
        arm_and_eod(1'b0, 1'b1);
        run_tx(1'b1, -1, -1);
        chk(rec_byte(1) == 8'h3B, "R6", "crc of 0x00", rec_byte(1), 8'h3B);

        // R2 arming in the cycle after end-of-data, and in the same cycle
        @(negedge clk); eod_seen = 1'b1; eod_crc_ok = 1'b1;
        @(negedge clk); eod_seen = 1'b0; eod_crc_ok = 1'b0; cpu_arm = 1'b1;
        @(negedge clk); cpu_arm = 1'b0;
        chk(!arm_bit, "R2", "arm right after eod", arm_bit, 0);
        @(negedge clk); eod_seen = 1'b1; eod_crc_ok = 1'b1; cpu_arm = 1'b1;
        @(negedge clk); eod_seen = 1'b0; eod_crc_ok = 1'b0; cpu_arm = 1'b0;
        @(negedge clk);
        chk(!arm_bit && !sym_valid, "R2", "arm with eod", {arm_bit, sym_valid}, 0);

        // R3 end-of-data with a bad CRC drops the request
        npay = 1; pay[0] = 8'h77;
        arm_and_eod(1'b0, 1'b0);
        run_tx(1'b1, -1, -1);
        chk(nrec == 0 && !arm_bit, "R3", "bad-crc eod symbols/arm", nrec + 32'(arm_bit), 0);

        // R8 underrun: no second byte after the interrupt
        npay = 2; pay[0] = 8'hC3; pay[1] = 8'h11;
        arm_and_eod(1'b0, 1'b1);
        run_tx(1'b0, -1, -1);
        chk(nrec == 9, "R8", "symbols before underrun", nrec, 9);
        chk(flag_unr && !arm_bit, "R8", "underrun flag/arm", {flag_unr, arm_bit}, 2);

        // R12 flag stays set across a good frame, then clears on its strobe only
        npay = 1; pay[0] = 8'h3C;
        arm_and_eod(1'b1, 1'b1);
        run_tx(1'b1, -1, -1);
        chk(flag_unr, "R12", "underrun flag sticky", flag_unr, 1);
        cpu_flag_clr = 3'b011;
        @(negedge clk); cpu_flag_clr = 3'b000;
        chk(flag_unr, "R12", "other clear strobes ignored", flag_unr, 1);
        cpu_flag_clr = 3'b100;
        @(negedge clk); cpu_flag_clr = 3'b000;
        chk(!flag_unr, "R12", "underrun flag cleared", flag_unr, 0);

        // R9 arbitration lost mid-byte (symbol 4 = bit 3 of first byte)
        npay = 2; pay[0] = 8'hF0; pay[1] = 8'h0F;
        arm_and_eod(1'b0, 1'b1);
        run_tx(1'b1, 4, -1);
        chk(nrec == 5, "R9", "symbols after mid-byte loss", nrec, 5);
        chk(flag_arb && !arm_bit, "R9", "arb flag/arm", {flag_arb, arm_bit}, 2);

        // R13 next response CRC starts fresh after the abort
        npay = 1; pay[0] = 8'h00;
        arm_and_eod(1'b1, 1'b1);
        run_tx(1'b1, -1, -1);
        chk(rec_byte(1) == 8'h3B, "R13", "crc after abort", rec_byte(1), 8'h3B);

        // R10 arbitration lost on last bit (symbol 8) gives two 1 fill bits
        cpu_flag_clr = 3'b001;
        @(negedge clk); cpu_flag_clr = 3'b000;
        npay = 2; pay[0] = 8'h5A; pay[1] = 8'h01;
        arm_and_eod(1'b0, 1'b1);
        run_tx(1'b1, 8, -1);
        chk(nrec == 11, "R10", "symbols incl. fill", nrec, 11);
        chk(rec_bit[9] && rec_bit[10] && rec_kind[9] == 2'd0 && rec_kind[10] == 2'd0,
            "R10", "fill bits", {rec_bit[9], rec_bit[10]}, 3);
        chk(flag_arb && !arm_bit, "R10", "arb flag/arm", {flag_arb, arm_bit}, 2);

        // R11 bus error mid-byte aborts at once
        npay = 2; pay[0] = 8'h99; pay[1] = 8'h66;
        arm_and_eod(1'b0, 1'b1);
        run_tx(1'b1, -1, 6);
        chk(nrec == 7, "R11", "symbols before error", nrec, 7);
        chk(flag_err && !arm_bit && !sym_valid, "R11", "error flag/arm/valid",
            {flag_err, arm_bit, sym_valid}, 4);

        // R11 bus error while idle and unarmed is ignored
        cpu_flag_clr = 3'b010;
        @(negedge clk); cpu_flag_clr = 3'b000; bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        @(negedge clk);
        chk(!flag_err && !sym_valid, "R11", "idle error ignored", {flag_err, sym_valid}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule